// File: doc/BRIEF.md
# Latched Motor Stall Protection Controller

This block guards a three-phase brushless drive against a stalled rotor. While the drive is actively running, it times the gaps between Hall-sensor transitions. A quiet interval of about two seconds latches a stall fault, and the fault holds the low-side switches off. The analogue timing capacitor is replaced by a clock prescaler that produces a 1 kHz tick, plus two tick counters. One counter measures the stall window and the other measures the restart delay that follows an initial reset.

Only a few events clear the latched fault: selecting brake, reversing direction, a duty command that drops to zero and then rises again, or an undervoltage event. A thermal shutdown does not clear it. Selecting brake and undervoltage both act as an initial reset, and driving resumes only after a short restart delay. A 2-bit mode code selects between the power-saving modes and the tach-output modes, which differ in how the Hall-sensor bias is gated.

Every pin is a plain control or status level, or a single-cycle strobe. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `lockp_ctrl`

## Requirements
- R1: While reset is held, and directly after it: `lock_flt`=0, `restart_pend`=1 and `drv_en`=0.
- R2: The drive counts as running when brake, zero duty, undervoltage, thermal shutdown, restart pending and the latched fault are all inactive. While it is running, `LOCK_TICKS` consecutive ticks without a `hall_chg` pulse set `lock_flt`. One tick lasts `TICK_DIV` clock cycles.
- R3: A `hall_chg` pulse restarts the stall window. The window is held at zero whenever the drive is not running, so zero duty or brake never leads to a fault.
- R4: `drv_en` is 1 only when `lock_flt`, `tsd_flag` and `restart_pend` are all 0.
- R5: `sb_brake`=1 (brake selected) clears `lock_flt` by the next clock.
- R6: Any change of level on `dir_fwd` clears `lock_flt` by the next clock.
- R7: A 1-to-0 transition of `duty_zero` clears `lock_flt`. Holding `duty_zero` at 1 does not clear it.
- R8: Either `uv_flag`=1 or `sb_brake`=1 clears `lock_flt` and sets `restart_pend`. Once both inputs are 0, `restart_pend` falls after `RESTART_TICKS` ticks.
- R9: `tsd_flag` has no effect on `lock_flt`. A fault that is latched before or during a thermal shutdown is still set after the shutdown ends.
- R10: `mode` 2'b00 and 2'b11 are power-saving modes. In these modes `hall_bias_en` = !(`lock_flt` | `duty_zero` | `sb_brake`). In the tach-output modes, 2'b01 and 2'b10, `hall_bias_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_chg | input | 1 | One-cycle strobe on any Hall-state change |
| sb_brake | input | 1 | 1 = brake selected, 0 = start |
| dir_fwd | input | 1 | Rotation direction level |
| duty_zero | input | 1 | 1 = commanded duty judged to be 0% |
| uv_flag | input | 1 | Supply undervoltage detected |
| tsd_flag | input | 1 | Thermal shutdown active |
| mode | input | 2 | Mode code, see R10 |
| lock_flt | output | 1 | Latched stall fault |
| drv_en | output | 1 | Low-side output enable |
| hall_bias_en | output | 1 | Hall-sensor bias enable |
| restart_pend | output | 1 | Initial-reset restart delay in progress |

## Verification
The bench targets five corner cases. The first is Hall pulses that arrive just inside the stall window; a window that failed to restart on each pulse would latch a false fault. The second is a long zero-duty stretch, which would trip a timer that is not held at zero. The third is a thermal shutdown that starts and ends while the fault is set; a design that lets the thermal flag feed the release logic would drop the latch. The fourth is the difference between holding zero duty and leaving it: only the falling edge may release, so a level-sensitive design would release too early. The fifth is the restart delay after undervoltage and after brake; a wrong tick count there moves the return of `restart_pend` and `drv_en` by whole ticks, and the cycle-by-cycle reference model reports it.

// File: rtl/lockp_pkg.sv
package lockp_pkg;
  typedef enum logic [1:0] {
    MODE_B_SAVE = 2'b00,
    MODE_B_TACH = 2'b01,
    MODE_A_TACH = 2'b10,
    MODE_A_SAVE = 2'b11
  } drv_mode_e;

  function automatic logic saves_power(input logic [1:0] m);
    return (m == MODE_B_SAVE) || (m == MODE_A_SAVE);
  endfunction
endpackage

// File: rtl/lockp_tick_gen.sv
module lockp_tick_gen #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = $clog2(TICK_DIV + 1);
  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= wrap ? '0 : div_q + 1'b1;
      tick  <= wrap;
    end
  end
endmodule

// File: rtl/lockp_restart_timer.sv
module lockp_restart_timer #(
  parameter int RESTART_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic pend
);
  localparam int RW = $clog2(RESTART_TICKS + 1);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b1;
      cnt_q <= '0;
    end else if (hold) begin
      pend  <= 1'b1;
      cnt_q <= '0;
    end else if (pend && tick) begin
      if (cnt_q == RW'(RESTART_TICKS - 1)) pend <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PEND_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> pend); // R8
  AST_PEND_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(tick) && !$past(hold)); // R8
endmodule

// File: rtl/lockp_stall_timer.sv
module lockp_stall_timer #(
  parameter int LOCK_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic hall_chg,
  output logic expire
);
  localparam int LW = $clog2(LOCK_TICKS + 1);
  logic [LW-1:0] cnt_q;

  assign expire = run && tick && !hall_chg && (cnt_q == LW'(LOCK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || hall_chg) cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lockp_ctrl.sv
module lockp_ctrl
  import lockp_pkg::*;
#(
  parameter int TICK_DIV      = 250000,
  parameter int LOCK_TICKS    = 2000,
  parameter int RESTART_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hall_chg,
  input  logic       sb_brake,
  input  logic       dir_fwd,
  input  logic       duty_zero,
  input  logic       uv_flag,
  input  logic       tsd_flag,
  input  logic [1:0] mode,
  output logic       lock_flt,
  output logic       drv_en,
  output logic       hall_bias_en,
  output logic       restart_pend
);
  logic tick, expire, run, release_evt;
  logic lock_q, dir_q, dz_q;

  lockp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  lockp_restart_timer #(.RESTART_TICKS(RESTART_TICKS)) u_restart (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hold(sb_brake | uv_flag), .pend(restart_pend));

  assign run = !sb_brake && !duty_zero && !uv_flag && !tsd_flag
            && !restart_pend && !lock_q;

  lockp_stall_timer #(.LOCK_TICKS(LOCK_TICKS)) u_stall (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .hall_chg(hall_chg), .expire(expire));

  // Release events: brake, undervoltage, direction change, duty leaving zero.
  assign release_evt = sb_brake || uv_flag || (dir_fwd != dir_q)
                    || (dz_q && !duty_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      dir_q  <= 1'b0;
      dz_q   <= 1'b1;
    end else begin
      dir_q <= dir_fwd;
      dz_q  <= duty_zero;
      if (release_evt) lock_q <= 1'b0;
      else if (expire) lock_q <= 1'b1;
    end
  end

  assign lock_flt     = lock_q;
  assign drv_en       = !lock_q && !tsd_flag && !restart_pend;
  assign hall_bias_en = saves_power(mode) ? !(lock_q || duty_zero || sb_brake) : 1'b1;

  AST_LOCK_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flt) |-> !$past(hall_chg) && !$past(duty_zero)); // R2
  AST_NO_LOCK_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flt) |-> !$past(restart_pend)); // R3
  AST_BRAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    sb_brake |=> !lock_flt); // R5
  AST_UV_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !lock_flt && restart_pend); // R8
  AST_LOCKED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flt |-> !drv_en); // R4
endmodule

// File: tb/test_lockp_ctrl.sv
module test_lockp_ctrl;
  localparam int TD = 4, LT = 10, RT = 3;
  logic clk = 0, rst_n = 0;
  logic hall_chg = 0, sb_brake = 1, dir_fwd = 1, duty_zero = 0;
  logic uv_flag = 0, tsd_flag = 0;
  logic [1:0] mode = 2'b00;
  logic lock_flt, drv_en, hall_bias_en, restart_pend;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lockp_ctrl #(.TICK_DIV(TD), .LOCK_TICKS(LT), .RESTART_TICKS(RT)) i_lockp_ctrl (
    .clk(clk), .rst_n(rst_n), .hall_chg(hall_chg), .sb_brake(sb_brake),
    .dir_fwd(dir_fwd), .duty_zero(duty_zero), .uv_flag(uv_flag),
    .tsd_flag(tsd_flag), .mode(mode), .lock_flt(lock_flt), .drv_en(drv_en),
    .hall_bias_en(hall_bias_en), .restart_pend(restart_pend));

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_div, m_quiet, m_rwait;
  bit  m_tick, m_lock, m_pend, m_dir, m_dz;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_quiet = 0; m_rwait = 0;
      m_tick = 0; m_lock = 0; m_pend = 1; m_dir = 0; m_dz = 1;
    end else begin
      automatic bit running = !sb_brake && !duty_zero && !uv_flag && !tsd_flag && !m_pend && !m_lock;
      automatic bit trip = running && m_tick && !hall_chg && (m_quiet == LT - 1);
      automatic bit rel = sb_brake || uv_flag || (dir_fwd != m_dir) || (m_dz && !duty_zero);
      automatic bit old_tick = m_tick;
      if (!running || hall_chg) m_quiet = 0;
      else if (m_tick) m_quiet++;
      if (rel) m_lock = 0; else if (trip) m_lock = 1;
      if (sb_brake || uv_flag) begin m_pend = 1; m_rwait = 0; end
      else if (m_pend && old_tick) begin
        if (m_rwait == RT - 1) m_pend = 0; else m_rwait++;
      end
      m_tick = (m_div == TD - 1);
      m_div  = (m_div == TD - 1) ? 0 : m_div + 1;
      m_dir = dir_fwd; m_dz = duty_zero;
    end
  end

  always begin
    @(posedge clk); #1;
    if (!done) begin
      check("R2 lock_flt vs model", lock_flt, m_lock);
      check("R4 drv_en vs model", drv_en, !m_lock && !tsd_flag && !m_pend);
      check("R8 restart_pend vs model", restart_pend, m_pend);
      check("R10 hall_bias_en vs model", hall_bias_en,
            (mode == 2'b01 || mode == 2'b10) ? 1'b1 : !(m_lock || duty_zero || sb_brake));
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  initial begin
    cyc(5);
    check("R1 reset lock_flt", lock_flt, 0);
    check("R1 reset restart_pend", restart_pend, 1);
    check("R1 reset drv_en", drv_en, 0);
    rst_n = 1; cyc(10);
    check("R10 bias off in brake", hall_bias_en, 0);
    sb_brake = 0; cyc(20);
    check("R8 pend cleared after delay", restart_pend, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(30); hall_chg = 1; cyc(1); hall_chg = 0;
    end
    check("R3 hall pulses keep it unlocked", lock_flt, 0);
    duty_zero = 1; cyc(80);
    check("R3 zero duty holds timer", lock_flt, 0);
    duty_zero = 0; cyc(60);
    check("R2 stall latched", lock_flt, 1);
    check("R4 drive off when locked", drv_en, 0);
    check("R10 bias off when locked", hall_bias_en, 0);
    mode = 2'b01; cyc(2);
    check("R10 bias on in tach mode", hall_bias_en, 1);
    mode = 2'b11;
    tsd_flag = 1; cyc(20); tsd_flag = 0; cyc(10);
    check("R9 lock survives shutdown", lock_flt, 1);
    dir_fwd = 0; cyc(2);
    check("R6 dir toggle releases", lock_flt, 0);
    cyc(60);
    check("R2 relatch after dir", lock_flt, 1);
    duty_zero = 1; cyc(10);
    check("R7 zero duty alone keeps lock", lock_flt, 1);
    duty_zero = 0; cyc(2);
    check("R7 duty up releases", lock_flt, 0);
    cyc(60);
    sb_brake = 1; cyc(3);
    check("R5 brake releases", lock_flt, 0);
    check("R8 brake sets pend", restart_pend, 1);
    sb_brake = 0; cyc(80);
    check("R2 relatch after brake", lock_flt, 1);
    uv_flag = 1; cyc(3);
    check("R8 uv releases", lock_flt, 0);
    uv_flag = 0; cyc(4);
    check("R8 pend held during delay", restart_pend, 1);
    cyc(20);
    check("R8 pend ends", restart_pend, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule